// File: doc/BRIEF.md
# Asynchronous Timer Register Write Bridge

This block carries processor register writes from the I/O clock domain into the five registers of an 8-bit timer: the counter, two compare registers and two control registers. The timer side may be clocked by the I/O clock or by a separate slow clock pin. A write to one of these registers is first captured on the I/O side. When the timer runs from the clock pin, the captured value is handed across with a toggle request and acknowledge, using two-flop synchronizers in both directions.

A status register shows the two clock-configuration bits and one update-busy flag per timer register. A flag is set while a write to its register has not yet landed in the timer domain. Software polls the flag before writing again or before trusting a value. In synchronous mode the timer clock is the I/O clock, so a write lands on the next I/O edge and no flag is raised. Changing the clock-select bit while a transfer is in flight leaves the timer registers undefined. The same applies to writes whose flags are still set.

Top module: `async_timer_wbridge`

## Requirements
- R1: During and after reset the status register reads 0x00, all five timer-domain registers read 0 and the oscillator enable is low.
- R2: A write with select code 5 loads status bit 6 (external-clock enable) and bit 5 (clock-select, 1 = clock pin) from the write data. Bit 7 always reads 0. Bits 4 down to 0 are the busy flags of the counter (select 0), compare A (1), compare B (2), control A (3) and control B (4).
- R3: In asynchronous mode, a write to a timer register sets that register's busy flag on the I/O edge that accepts the write.
- R4: A busy flag clears only after the matching timer-domain register holds the value last written to it. Whenever a flag reads 0, that register holds its last written value.
- R5: A write to a register whose flag is already set replaces the pending value and keeps the flag set without a gap. Once the flag clears, the register holds the most recent of those writes.
- R6: In synchronous mode (bit 5 = 0), a register write appears in the timer-domain register on the next I/O clock edge, and the busy flags stay 0.
- R7: While a request is in flight and not yet acknowledged, the staged value presented to the timer domain does not change.
- R8: The crystal-oscillator enable output is high only when clock-select is 1 and external-clock enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_io | input | 1 | Processor I/O clock |
| rst_io_n | input | 1 | Synchronous active-low reset, I/O domain |
| clk_pin | input | 1 | Asynchronous timer clock pin |
| rst_tm_n | input | 1 | Synchronous active-low reset, timer domain |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Target: 0 counter, 1 cmp A, 2 cmp B, 3 ctl A, 4 ctl B, 5 status |
| wr_data | input | 8 | Write data |
| status_q | output | 8 | Status register: config bits and busy flags |
| osc_en | output | 1 | Crystal oscillator enable |
| tm_cnt | output | 8 | Timer-domain counter register |
| tm_cmpa | output | 8 | Timer-domain compare A register |
| tm_cmpb | output | 8 | Timer-domain compare B register |
| tm_ctla | output | 8 | Timer-domain control A register |
| tm_ctlb | output | 8 | Timer-domain control B register |

## Verification
A request toggle or acknowledge that goes out of step shows at the ports as a flag that stays set forever, or as a flag that reads 0 while the timer-domain register still holds an older value. Either fault appears within a few slow-clock periods of the write. A staged value that changes mid-flight lands a value other than the last one written. This is visible when the flag clears, roughly two slow periods plus two I/O cycles after the write. A faulty synchronous path shows one I/O cycle after the write, either as a raised flag or as a register that has not yet changed.

// File: rtl/atw_pkg.sv
// Shared constants and select codes for the asynchronous timer write bridge.
package atw_pkg;
    localparam int DW        = 8;   // timer register width
    localparam int NREG      = 5;   // number of bridged timer registers
    localparam int SELW      = 3;   // width of the write select
    localparam int BIT_EXT   = 6;   // status bit: external clock enable
    localparam int BIT_ASYNC = 5;   // status bit: clock select

    typedef enum logic [SELW-1:0] {
        SEL_CNT  = 3'd0,
        SEL_CMPA = 3'd1,
        SEL_CMPB = 3'd2,
        SEL_CTLA = 3'd3,
        SEL_CTLB = 3'd4,
        SEL_STAT = 3'd5
    } sel_e;
endpackage

// File: rtl/atw_sync.sv
// Two-flop synchronizer for a single level signal.
// Assumes the input is a level (toggle) that is held for at least two
// destination clock periods between changes.
module atw_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    // capture the foreign level through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/atw_io_chan.sv
// I/O-side channel for one timer register.
// Captures writes, presents a stable staged value with a request toggle,
// and keeps a shadow copy for writes that arrive while a transfer is in
// flight. Assumes ack_s is the timer acknowledge toggle already synchronized.
module atw_io_chan #(
    parameter int DW = 8
) (
    input  logic          clk_io,
    input  logic          rst_io_n,
    input  logic          async_sel,
    input  logic          wr_hit,
    input  logic [DW-1:0] wr_data,
    input  logic          ack_s,
    output logic          req_tgl,
    output logic [DW-1:0] stage,
    output logic          busy
);
    logic [DW-1:0] shadow;
    logic          dirty;
    logic          idle;

    assign idle = (req_tgl == ack_s);
    assign busy = !idle || dirty;

    // stage writes, launch transfers, queue writes that arrive mid-flight
    always_ff @(posedge clk_io) begin
        if (!rst_io_n) begin
            req_tgl <= 1'b0;
            stage   <= '0;
            shadow  <= '0;
            dirty   <= 1'b0;
        end else if (async_sel) begin
            if (idle) begin
                if (wr_hit) begin
                    stage   <= wr_data;
                    req_tgl <= ~req_tgl;
                    dirty   <= 1'b0;
                end else if (dirty) begin
                    stage   <= shadow;
                    req_tgl <= ~req_tgl;
                    dirty   <= 1'b0;
                end
            end else if (wr_hit) begin
                shadow <= wr_data;
                dirty  <= 1'b1;
            end
        end else begin
            dirty <= 1'b0;
            if (wr_hit) begin
                stage <= wr_data;
            end
        end
    end
endmodule

// File: rtl/atw_tm_reg.sv
// Timer-domain register for one bridged value.
// Loads the staged value when the synchronized request toggle differs from
// the local acknowledge, and echoes the request back as the acknowledge.
// In synchronous mode the timer clock is the I/O clock and direct_we loads
// the value on the same edge that accepts the write.
module atw_tm_reg #(
    parameter int DW = 8
) (
    input  logic          clk_tm,
    input  logic          rst_tm_n,
    input  logic          req_tgl,
    input  logic [DW-1:0] stage,
    input  logic          direct_we,
    input  logic [DW-1:0] direct_d,
    output logic [DW-1:0] q,
    output logic          ack_tgl
);
    logic req_s;

    atw_sync req_sync_i (
        .clk   (clk_tm),
        .rst_n (rst_tm_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    // land the value and acknowledge in the same timer cycle
    always_ff @(posedge clk_tm) begin
        if (!rst_tm_n) begin
            q       <= '0;
            ack_tgl <= 1'b0;
        end else begin
            ack_tgl <= req_s;
            if (direct_we) begin
                q <= direct_d;
            end else if (req_s != ack_tgl) begin
                q <= stage;
            end
        end
    end
endmodule

// File: rtl/async_timer_wbridge.sv
// Register write bridge between the processor I/O clock and an 8-bit
// timer that may run from a separate clock pin.
// Assumes the clock-select bit is changed only while all busy flags are
// clear; otherwise the timer registers are undefined afterwards.
module async_timer_wbridge
    import atw_pkg::*;
(
    input  logic          clk_io,
    input  logic          rst_io_n,
    input  logic          clk_pin,
    input  logic          rst_tm_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [7:0]    wr_data,
    output logic [7:0]    status_q,
    output logic          osc_en,
    output logic [7:0]    tm_cnt,
    output logic [7:0]    tm_cmpa,
    output logic [7:0]    tm_cmpb,
    output logic [7:0]    tm_ctla,
    output logic [7:0]    tm_ctlb
);
    logic                     ext_q;
    logic                     async_q;
    logic                     clk_tm;
    logic [NREG-1:0]          busy;
    logic [NREG-1:0]          req_v;
    logic [NREG-1:0]          ack_tm;
    logic [NREG-1:0]          ack_s;
    logic [NREG-1:0][DW-1:0]  stage_a;
    logic [NREG-1:0][DW-1:0]  q_a;

    // clock-configuration bits, written through the status select
    always_ff @(posedge clk_io) begin
        if (!rst_io_n) begin
            ext_q   <= 1'b0;
            async_q <= 1'b0;
        end else if (wr_en && wr_sel == SEL_STAT) begin
            ext_q   <= wr_data[BIT_EXT];
            async_q <= wr_data[BIT_ASYNC];
        end
    end

    assign clk_tm = async_q ? clk_pin : clk_io;
    assign osc_en = async_q & ~ext_q;

    for (genvar i = 0; i < NREG; i++) begin : g_chan
        logic hit;
        assign hit = wr_en && (wr_sel == SELW'(i));

        atw_io_chan #(.DW(DW)) io_i (
            .clk_io    (clk_io),
            .rst_io_n  (rst_io_n),
            .async_sel (async_q),
            .wr_hit    (hit),
            .wr_data   (wr_data),
            .ack_s     (ack_s[i]),
            .req_tgl   (req_v[i]),
            .stage     (stage_a[i]),
            .busy      (busy[i])
        );

        atw_sync ack_sync_i (
            .clk   (clk_io),
            .rst_n (rst_io_n),
            .d     (ack_tm[i]),
            .q     (ack_s[i])
        );

        atw_tm_reg #(.DW(DW)) tm_i (
            .clk_tm    (clk_tm),
            .rst_tm_n  (rst_tm_n),
            .req_tgl   (req_v[i]),
            .stage     (stage_a[i]),
            .direct_we (hit && !async_q),
            .direct_d  (wr_data),
            .q         (q_a[i]),
            .ack_tgl   (ack_tm[i])
        );

        assign status_q[NREG-1-i] = busy[i];
    end

    assign status_q[7]         = 1'b0;
    assign status_q[BIT_EXT]   = ext_q;
    assign status_q[BIT_ASYNC] = async_q;

    assign tm_cnt  = q_a[SEL_CNT];
    assign tm_cmpa = q_a[SEL_CMPA];
    assign tm_cmpb = q_a[SEL_CMPB];
    assign tm_ctla = q_a[SEL_CTLA];
    assign tm_ctlb = q_a[SEL_CTLB];
endmodule

// File: rtl/atw_chk.sv
// Protocol checks for the write bridge, bound onto the top module.
module atw_chk
    import atw_pkg::*;
(
    input logic                    clk_io,
    input logic                    rst_io_n,
    input logic                    wr_en,
    input logic [2:0]              wr_sel,
    input logic [7:0]              wr_data,
    input logic [7:0]              status_q,
    input logic [NREG-1:0]         req_v,
    input logic [NREG-1:0]         ack_s,
    input logic [NREG-1:0][DW-1:0] stage_a
);
    // R2
    stat_write_chk: assert property (@(posedge clk_io) disable iff (!rst_io_n)
        (wr_en && wr_sel == SEL_STAT) |=> (status_q[6:5] == $past(wr_data[6:5])));

    for (genvar i = 0; i < NREG; i++) begin : g_c
        // R3
        busy_set_chk: assert property (@(posedge clk_io) disable iff (!rst_io_n)
            (status_q[BIT_ASYNC] && wr_en && wr_sel == SELW'(i)) |=> status_q[NREG-1-i]);
        // R5
        busy_no_drop_on_wr_chk: assert property (@(posedge clk_io) disable iff (!rst_io_n)
            ($fell(status_q[NREG-1-i]) && status_q[BIT_ASYNC] && $past(status_q[BIT_ASYNC]))
            |-> !$past(wr_en && wr_sel == SELW'(i)));
        // R7
        stage_hold_chk: assert property (@(posedge clk_io) disable iff (!rst_io_n)
            (status_q[BIT_ASYNC] && (req_v[i] != ack_s[i]) && $past(req_v[i] != ack_s[i]))
            |-> $stable(stage_a[i]));
        // R6
        sync_no_busy_chk: assert property (@(posedge clk_io) disable iff (!rst_io_n)
            (!status_q[BIT_ASYNC] && !status_q[NREG-1-i])
            |=> (!status_q[NREG-1-i] || status_q[BIT_ASYNC]));
    end
endmodule

bind async_timer_wbridge atw_chk chk_i (
    .clk_io   (clk_io),
    .rst_io_n (rst_io_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .status_q (status_q),
    .req_v    (req_v),
    .ack_s    (ack_s),
    .stage_a  (stage_a)
);

// File: tb/async_timer_wbridge_tb.sv
// Self-checking bench: two unrelated clocks, directed corners plus seeded
// random write traffic in asynchronous mode.
module async_timer_wbridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PIN_HALF   = 23;

    logic       clk_io = 1'b0;
    logic       clk_pin = 1'b0;
    logic       rst_io_n = 1'b0;
    logic       rst_tm_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] status_q;
    logic       osc_en;
    logic [7:0] tm_cnt, tm_cmpa, tm_cmpb, tm_ctla, tm_ctlb;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    logic [7:0] exp_v [5];
    bit   exp_ok [5];

    async_timer_wbridge dut_i (
        .clk_io(clk_io), .rst_io_n(rst_io_n), .clk_pin(clk_pin), .rst_tm_n(rst_tm_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .status_q(status_q),
        .osc_en(osc_en), .tm_cnt(tm_cnt), .tm_cmpa(tm_cmpa), .tm_cmpb(tm_cmpb),
        .tm_ctla(tm_ctla), .tm_ctlb(tm_ctlb)
    );

    initial forever #(CLK_PERIOD/2) clk_io = ~clk_io;
    initial forever #(PIN_HALF) clk_pin = ~clk_pin;

    function automatic logic [7:0] tm_val(int i);
        case (i)
            0: return tm_cnt;
            1: return tm_cmpa;
            2: return tm_cmpb;
            3: return tm_ctla;
            default: return tm_ctlb;
        endcase
    endfunction

    function automatic logic busy_of(int i);
        return status_q[4-i];
    endfunction

    function automatic logic exp_osc(logic async_b, logic ext_b);
        return async_b && !ext_b;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // R4: every idle flag must mean the last written value is present
    task automatic scan();
        for (int i = 0; i < 5; i++) begin
            if (exp_ok[i] && !busy_of(i))
                chk(tm_val(i) == exp_v[i], "R4 idle-flag value", tm_val(i), exp_v[i]);
        end
    endtask

    // one write cycle; returns at the negedge after the accepting edge
    task automatic do_wr(int sel, logic [7:0] d);
        @(negedge clk_io);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
        @(negedge clk_io);
        wr_en = 1'b0;
        if (sel < 5) begin
            exp_v[sel] = d;
            exp_ok[sel] = 1'b1;
        end
    endtask

    task automatic idle_wait(int i);
        int n = 0;
        while (busy_of(i) && n < 400) begin
            @(negedge clk_io);
            scan();
            n++;
        end
        chk(!busy_of(i), "R4 flag clears", busy_of(i), 0);
        chk(tm_val(i) == exp_v[i], "R4 landed value", tm_val(i), exp_v[i]);
    endtask

    task automatic set_mode(logic async_b, logic ext_b);
        do_wr(5, {1'b0, ext_b, async_b, 5'b0});
        for (int i = 0; i < 5; i++) exp_ok[i] = 1'b0;
        chk(status_q[6:5] == {ext_b, async_b}, "R2 config bits", status_q[6:5], {ext_b, async_b});
        chk(status_q[7] == 1'b0, "R2 bit7 zero", status_q[7], 0);
        chk(osc_en == exp_osc(async_b, ext_b), "R8 osc enable", osc_en, exp_osc(async_b, ext_b));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed = 0;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 5; i++) begin exp_v[i] = '0; exp_ok[i] = 1'b0; end
        repeat (6) @(negedge clk_io);
        // R1 values while in reset
        chk(status_q == 8'h00, "R1 status in reset", status_q, 0);
        rst_io_n = 1'b1; rst_tm_n = 1'b1;
        @(negedge clk_io);
        chk(status_q == 8'h00, "R1 status after reset", status_q, 0);
        chk(osc_en == 1'b0, "R1 osc enable", osc_en, 0);
        for (int i = 0; i < 5; i++)
            chk(tm_val(i) == 8'h00, "R1 timer reg", tm_val(i), 0);

        // R6 synchronous mode writes land next edge, no busy flag
        for (int i = 0; i < 5; i++) begin
            logic [7:0] d = 8'($urandom);
            do_wr(i, d);
            chk(tm_val(i) == d, "R6 sync load", tm_val(i), d);
            chk(status_q[4:0] == 5'b0, "R6 sync flags", status_q[4:0], 0);
        end
        set_mode(1'b0, 1'b1);
        set_mode(1'b1, 1'b1);
        set_mode(1'b1, 1'b0);
        repeat (10) @(negedge clk_io);

        // R3 directed async write to the counter
        do_wr(0, 8'hA5);
        chk(busy_of(0) == 1'b1, "R3 busy set", busy_of(0), 1);
        chk(status_q[4:0] == 5'b10000, "R2 busy position", status_q[4:0], 5'b10000);
        idle_wait(0);

        // R5 and R7: back-to-back writes while busy
        do_wr(1, 8'h11);
        do_wr(1, 8'h22);
        chk(busy_of(1) == 1'b1, "R5 busy held", busy_of(1), 1);
        repeat (3) @(negedge clk_io);
        do_wr(1, 8'h33);
        chk(busy_of(1) == 1'b1, "R5 busy held late", busy_of(1), 1);
        idle_wait(1);
        chk(tm_cmpa == 8'h33, "R5 R7 last write lands", tm_cmpa, 8'h33);

        // seeded random traffic in async mode
        for (int k = 0; k < 300; k++) begin
            int sel = int'($urandom_range(4, 0));
            int gap = int'($urandom_range(3, 0));
            do_wr(sel, 8'($urandom));
            chk(busy_of(sel) == 1'b1, "R3 busy after write", busy_of(sel), 1);
            scan();
            for (int g = 0; g < gap; g++) begin
                @(negedge clk_io);
                scan();
            end
            seed++;
        end
        for (int i = 0; i < 5; i++) idle_wait(i);

        // back to synchronous mode
        set_mode(1'b0, 1'b0);
        do_wr(4, 8'h5C);
        chk(tm_ctlb == 8'h5C, "R6 sync after async", tm_ctlb, 8'h5C);
        chk(status_q[4:0] == 5'b0, "R6 flags idle", status_q[4:0], 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule